// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, for each incoming frame, whether the receiver keeps it. The receive path presents the frame's 48-bit destination address for one clock with a valid strobe. One cycle later the block returns a keep/drop decision and a code that names the class of match behind the decision. The class is one of: own station address, all-ones broadcast, multicast, or promiscuous capture.

The station address and three configuration levels come from outside the block. The levels are promiscuous capture, station-match disable and broadcast disable. Multicast membership is computed elsewhere, for example by a hash filter, and arrives as a single hit level. The block uses that hit only for group addresses that are not broadcast. Each match class can be switched off on its own, and promiscuous capture keeps every frame whatever the other settings are.

Address bytes are numbered in the order they cross the wire. The first byte received sits in bits [7:0], the second in bits [15:8], and so on. The station address uses the same layout, so the two are compared byte for byte.

Top module: `rxaf_filter`

## Requirements
- R1: With `cfg_promisc` high, every presented address gives `accept`=1. When no other class matches, `match_type` is 4 (promiscuous).
- R2: An address equal to `station_addr` in all six bytes, with `cfg_phys_dis` low, gives `accept`=1 and `match_type`=1 (station).
- R3: With `cfg_phys_dis` high, an address equal to the station address never gives `match_type`=1. Such a frame can still be kept through the broadcast, multicast or promiscuous class.
- R4: The all-ones address with `cfg_bcast_dis` low gives `match_type`=2 (broadcast). With `cfg_bcast_dis` high it never gives code 2.
- R5: An address with bit 0 set (the group bit, the lowest bit of the first wire byte) that is not all-ones gives `match_type`=3 (multicast) only when `mcast_hit` is high.
- R6: When several classes apply, the reported class follows the fixed priority station > broadcast > multicast > promiscuous.
- R7: Results appear on the clock edge after the one that samples `dst_valid`. `res_valid` is high for exactly that cycle. In every other cycle `accept` is 0 and `match_type` is 0 (none).
- R8: While `rst_n` is low, on the synchronous edge, the outputs clear to `res_valid`=0, `accept`=0 and `match_type`=0. With all configuration levels low, as they are after reset, a broadcast frame is kept.
- R9: `accept` is high exactly when `match_type` is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dst_valid | input | 1 | Destination address strobe, one cycle per frame |
| dst_addr | input | 48 | Destination address, first wire byte in [7:0] |
| station_addr | input | 48 | Own station address, same byte layout |
| mcast_hit | input | 1 | External multicast membership result |
| cfg_promisc | input | 1 | Keep every frame |
| cfg_phys_dis | input | 1 | Disable station-address matching |
| cfg_bcast_dis | input | 1 | Disable broadcast acceptance |
| res_valid | output | 1 | Decision valid, one cycle after the strobe |
| accept | output | 1 | Keep the frame |
| match_type | output | 3 | 0 none, 1 station, 2 broadcast, 3 multicast, 4 promiscuous |

## Verification
Every stage is combinational up to a single output register, so a wrong internal decision shows on `accept` or `match_type` in the first cycle after the strobe. Nothing can hide in the block for later cycles. The mistakes most likely to slip through are a byte compare that is wrong in one lane only, and the group bit taken from the wrong end of the address. Single-byte differences in every lane and both ends of the address are therefore driven on purpose, and the bench then covers every mix of configuration levels at random.

// File: rtl/rxaf_pkg.sv
// Package: shared types for the receive address filter.
// Assumes a 3-bit result code; the code values are visible at the ports.
package rxaf_pkg;
    localparam int unsigned MT_W = 3;

    typedef enum logic [MT_W-1:0] {
        MT_NONE    = 3'd0,
        MT_PHYS    = 3'd1,
        MT_BCAST   = 3'd2,
        MT_MCAST   = 3'd3,
        MT_PROMISC = 3'd4
    } match_t;

    typedef struct packed {
        logic phys;
        logic bcast;
        logic mcast;
    } hits_t;
endpackage

// File: rtl/rxaf_station_cmp.sv
// Module: byte-lane equality of destination and station address.
// Assumes both addresses use the same byte layout (first wire byte lowest).
module rxaf_station_cmp #(
    parameter int unsigned BYTES  = 6,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned AW    = BYTES * BYTE_W
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] station,
    output logic          equal
);
    logic [BYTES-1:0] lane_eq;

    // One comparator per byte lane.
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign lane_eq[b] = (addr[b*BYTE_W +: BYTE_W] == station[b*BYTE_W +: BYTE_W]);
    end

    // All lanes must agree.
    assign equal = &lane_eq;
endmodule

// File: rtl/rxaf_classify.sv
// Module: turns the address and configuration into per-class hit flags.
// Assumes the group bit is bit 0 (lowest bit of the first wire byte).
module rxaf_classify
    import rxaf_pkg::*;
#(
    parameter int unsigned BYTES  = 6,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned AW    = BYTES * BYTE_W
) (
    input  logic [AW-1:0] addr,
    input  logic          sta_equal,
    input  logic          mcast_hit,
    input  logic          phys_dis,
    input  logic          bcast_dis,
    output hits_t         hits
);
    logic all_ones;
    logic group_bit;

    // Address shape decode.
    always_comb begin
        all_ones  = &addr;
        group_bit = addr[0];
    end

    // Per-class hits with their disables applied.
    always_comb begin
        hits.phys  = sta_equal & ~phys_dis;
        hits.bcast = all_ones & ~bcast_dis;
        hits.mcast = group_bit & ~all_ones & mcast_hit;
    end
endmodule

// File: rtl/rxaf_decide.sv
// Module: applies class priority and registers the decision.
// Assumes a synchronous active-low reset; result lives one cycle only.
module rxaf_decide
    import rxaf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  hits_t           hits,
    input  logic            promisc,
    output logic            res_valid,
    output logic            accept,
    output logic [MT_W-1:0] match_type
);
    match_t cls_d;

    // Priority: station, broadcast, multicast, promiscuous.
    always_comb begin
        if (hits.phys)       cls_d = MT_PHYS;
        else if (hits.bcast) cls_d = MT_BCAST;
        else if (hits.mcast) cls_d = MT_MCAST;
        else if (promisc)    cls_d = MT_PROMISC;
        else                 cls_d = MT_NONE;
    end

    // Output register, cleared whenever no address is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            accept     <= 1'b0;
            match_type <= MT_NONE;
        end else if (valid) begin
            res_valid  <= 1'b1;
            accept     <= (cls_d != MT_NONE);
            match_type <= cls_d;
        end else begin
            res_valid  <= 1'b0;
            accept     <= 1'b0;
            match_type <= MT_NONE;
        end
    end
endmodule

// File: rtl/rxaf_filter.sv
// Module: receive destination address filter, top level.
// Assumes one address strobe per frame; decision one cycle later.
module rxaf_filter
    import rxaf_pkg::*;
#(
    parameter int unsigned BYTES  = 6,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned AW    = BYTES * BYTE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dst_valid,
    input  logic [AW-1:0]   dst_addr,
    input  logic [AW-1:0]   station_addr,
    input  logic            mcast_hit,
    input  logic            cfg_promisc,
    input  logic            cfg_phys_dis,
    input  logic            cfg_bcast_dis,
    output logic            res_valid,
    output logic            accept,
    output logic [MT_W-1:0] match_type
);
    logic  sta_equal;
    hits_t hits;

    rxaf_station_cmp #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_cmp (
        .addr    (dst_addr),
        .station (station_addr),
        .equal   (sta_equal)
    );

    rxaf_classify #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_cls (
        .addr      (dst_addr),
        .sta_equal (sta_equal),
        .mcast_hit (mcast_hit),
        .phys_dis  (cfg_phys_dis),
        .bcast_dis (cfg_bcast_dis),
        .hits      (hits)
    );

    rxaf_decide u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (dst_valid),
        .hits       (hits),
        .promisc    (cfg_promisc),
        .res_valid  (res_valid),
        .accept     (accept),
        .match_type (match_type)
    );
endmodule

// File: rtl/rxaf_checker.sv
// Module: property checker for rxaf_filter, bound to every instance.
// Assumes the default 48-bit address; observes ports only.
module rxaf_checker #(
    parameter int unsigned AW = 48
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dst_valid,
    input logic [AW-1:0] dst_addr,
    input logic [AW-1:0] station_addr,
    input logic          mcast_hit,
    input logic          cfg_promisc,
    input logic          cfg_phys_dis,
    input logic          cfg_bcast_dis,
    input logic          res_valid,
    input logic          accept,
    input logic [2:0]    match_type
);
    logic bc_addr;
    logic sta_addr;
    assign bc_addr  = &dst_addr;
    assign sta_addr = (dst_addr == station_addr);

    // R1: promiscuous capture keeps everything.
    p_promisc_keeps_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid && cfg_promisc |=> accept);

    // R2: enabled station match reports station class.
    p_station_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid && sta_addr && !cfg_phys_dis |=> match_type == 3'd1);

    // R3: disabled station match never reports station class.
    p_station_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid && cfg_phys_dis |=> match_type != 3'd1);

    // R4: disabled broadcast never reports broadcast class.
    p_bcast_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid && cfg_bcast_dis |=> match_type != 3'd2);

    // R5: multicast class needs the external hit.
    p_mcast_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid && !mcast_hit |=> match_type != 3'd3);

    // R7: no strobe, no result.
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_valid |=> !res_valid && !accept && match_type == 3'd0);

    // R7: a strobe always yields a result next cycle.
    p_result_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid |=> res_valid);

    // R9: keep flag agrees with the class code.
    p_accept_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> accept == (match_type != 3'd0));

    // R6: broadcast outranks multicast and promiscuous.
    p_bcast_rank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid && bc_addr && !cfg_bcast_dis && !(sta_addr && !cfg_phys_dis)
        |=> match_type == 3'd2);
endmodule

bind rxaf_filter rxaf_checker #(.AW(AW)) u_rxaf_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .dst_valid     (dst_valid),
    .dst_addr      (dst_addr),
    .station_addr  (station_addr),
    .mcast_hit     (mcast_hit),
    .cfg_promisc   (cfg_promisc),
    .cfg_phys_dis  (cfg_phys_dis),
    .cfg_bcast_dis (cfg_bcast_dis),
    .res_valid     (res_valid),
    .accept        (accept),
    .match_type    (match_type)
);

// File: tb/rxaf_filter_tb.sv
`timescale 1ns/1ps
// Bench: behavioural reference compared with the outputs at every negedge.
module rxaf_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dst_valid = 1'b0;
    logic [47:0] dst_addr = '0;
    logic [47:0] station_addr = 48'h0A_54_32_10_FE_02;
    logic        mcast_hit = 1'b0;
    logic        cfg_promisc = 1'b0;
    logic        cfg_phys_dis = 1'b0;
    logic        cfg_bcast_dis = 1'b0;
    logic        res_valid;
    logic        accept;
    logic [2:0]  match_type;

    int checks = 0;
    int errors = 0;

    // Expectation for the cycle after the last drive.
    logic        exp_v = 1'b0;
    logic        exp_acc = 1'b0;
    logic [2:0]  exp_mt = 3'd0;
    string       exp_tag = "R8";

    always #2.5 clk = ~clk;

    rxaf_filter u_dut (
        .clk(clk), .rst_n(rst_n), .dst_valid(dst_valid), .dst_addr(dst_addr),
        .station_addr(station_addr), .mcast_hit(mcast_hit),
        .cfg_promisc(cfg_promisc), .cfg_phys_dis(cfg_phys_dis),
        .cfg_bcast_dis(cfg_bcast_dis), .res_valid(res_valid),
        .accept(accept), .match_type(match_type)
    );

    // Reference: class codes 0 none, 1 station, 2 broadcast, 3 multicast, 4 promiscuous.
    function automatic logic [2:0] ref_class(input logic [47:0] a, input logic [47:0] s,
                                             input logic hit, input logic p,
                                             input logic pd, input logic bd);
        logic bc;
        bc = (a == 48'hFFFF_FFFF_FFFF);
        if (a == s && !pd)           return 3'd1;
        if (bc && !bd)               return 3'd2;
        if (a[0] && !bc && hit)      return 3'd3;
        if (p)                       return 3'd4;
        return 3'd0;
    endfunction

    task automatic compare();
        checks++;
        if (res_valid !== exp_v || accept !== exp_acc || match_type !== exp_mt) begin
            errors++;
            $display("FAIL %s: got valid=%0b accept=%0b type=%0d, expected valid=%0b accept=%0b type=%0d",
                     exp_tag, res_valid, accept, match_type, exp_v, exp_acc, exp_mt);
        end
    endtask

    // One cycle: check the previous result, then drive the next inputs.
    task automatic step(input logic v, input logic [47:0] a, input logic hit,
                        input logic p, input logic pd, input logic bd, input string tag);
        logic [2:0] c;
        @(negedge clk);
        compare();
        dst_valid = v; dst_addr = a; mcast_hit = hit;
        cfg_promisc = p; cfg_phys_dis = pd; cfg_bcast_dis = bd;
        c = v ? ref_class(a, station_addr, hit, p, pd, bd) : 3'd0;
        exp_v = rst_n && v;
        exp_mt = rst_n ? c : 3'd0;
        exp_acc = rst_n && (c != 3'd0);
        exp_tag = tag;
    endtask

    localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;

    initial begin : watchdog
        #1000000;
        errors++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        // R8: reset holds outputs clear, even with a strobe present.
        step(1'b1, BC, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
        step(1'b1, station_addr, 1'b0, 1'b1, 1'b0, 1'b0, "R8");
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
        @(negedge clk); rst_n = 1'b1;
        // R8: broadcast kept with all configuration low after reset.
        step(1'b1, BC, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
        // R7: idle cycles stay quiet, single-cycle result.
        step(1'b0, BC, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        // R2: station match.
        step(1'b1, station_addr, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        // R2: one-byte difference in every lane, both ends of each byte.
        for (int b = 0; b < 6; b++) begin
            step(1'b1, station_addr ^ (48'h01 << (8*b)), 1'b0, 1'b0, 1'b0, 1'b0, "R2");
            step(1'b1, station_addr ^ (48'h80 << (8*b)), 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        end
        // R3: station disable, then kept through promiscuous.
        step(1'b1, station_addr, 1'b1, 1'b0, 1'b1, 1'b0, "R3");
        step(1'b1, station_addr, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
        // R4: broadcast disable.
        step(1'b1, BC, 1'b1, 1'b0, 1'b0, 1'b1, "R4");
        step(1'b1, BC, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        // R5: multicast with and without hit, group bit at bit 0 not bit 47.
        step(1'b1, 48'h1234_5678_9A01, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
        step(1'b1, 48'h1234_5678_9A01, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        step(1'b1, 48'h8234_5678_9A00, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
        // R1: promiscuous on an unrelated individual address.
        step(1'b1, 48'h0000_0000_0002, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
        // R6: station outranks broadcast when station is all-ones.
        station_addr = BC;
        step(1'b1, BC, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
        step(1'b1, BC, 1'b1, 1'b1, 1'b1, 1'b0, "R6");
        step(1'b1, BC, 1'b1, 1'b1, 1'b1, 1'b1, "R6");
        station_addr = 48'h0A_54_32_10_FE_02;
        // R6, R9: random mix of address shapes and configuration.
        for (int i = 0; i < 2000; i++) begin
            logic [47:0] a;
            int unsigned k;
            k = $urandom % 4;
            a = {16'($urandom), 32'($urandom)};
            if (k == 0) a = station_addr;
            else if (k == 1) a = BC;
            else if (k == 2) a[0] = 1'b1;
            step(1'($urandom % 4 != 0), a, 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), (i % 2 == 0) ? "R6" : "R9");
        end
        step(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        @(negedge clk);
        compare();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule